// File: doc/BRIEF.md
# Flash Program and Erase Register Block

This block sits between a processor's byte-wide register bus and an embedded flash macro. Software sets a 16-bit word address through two address bytes, then starts a page erase, a word-programming session, or an erase followed by programming. During programming, software pushes bytes into a data port. Every four bytes are packed into one word and offered to the flash on a valid/ready stream. After each word is accepted, the word address steps forward by one, so software can stream several words in one session. A session ends when no new byte arrives within a timeout window. An operation aimed at a page whose lock input is high is refused, and an abort flag is raised.

The same control register carries a two-bit cache mode. The value read back is always the mode in force. Writing a different value raises a request toward the cache. The new mode takes effect only when the cache acknowledges. Mode writes made while a request is outstanding are discarded.

The register bus is a plain single-cycle write port with combinational read data. The word stream toward the flash follows valid/ready rules. Once valid is raised, the word and its address are held steady until ready is seen. The flash holds off programming simply by keeping ready low. While ready is low and four bytes are held, the buffer is full and any further data-port bytes are dropped.

Top module: `flash_prog_regs`

## Requirements
- R1: After reset the control register (offset 0) reads 0x04, the low address byte (offset 1) and high address byte (offset 2) read 0x00, and the data port (offset 3) reads 0x00.
- R2: Control register bits read as {busy, full, abort, 0, mode[1:0], write, erase} from bit 7 down to bit 0; busy is 1 exactly while write or erase is 1.
- R3: The data port always reads 0. A byte written to it is taken only while write is 1. Bytes are packed little-endian: the first byte goes to word bits 7:0.
- R4: Full (bit 6) rises once four bytes are held. Bytes written while full is set are dropped. Full clears in the cycle after the word is accepted on the stream.
- R5: While word_valid is high and word_ready is low, word_valid stays high and word_data and word_addr do not change.
- R6: Each accepted word is presented at the current address {high byte, low byte}. After acceptance the 16-bit address increments by one, carrying from the low byte into the high byte, and the new value is readable at offsets 1 and 2.
- R7: The page number is high-byte bits 7:1. Starting an erase or a write on a locked page issues nothing toward the flash, sets abort, and leaves write and erase at 0. A word that becomes ready for a locked page during a session ends the session the same way. Any accepted start on an unlocked page clears abort.
- R8: Writing 1 to both write and erase pulses erase_start with erase_page set to the page. No word is offered until erase_done has been seen; the programming session then follows.
- R9: While busy, writes to the write and erase bits have no effect: setting either bit adds nothing, and writing 0 cancels nothing.
- R10: A programming session ends, clearing write and busy, once WRITE_TIMEOUT cycles pass with no byte accepted and no full word waiting. Partial bytes are discarded.
- R11: Writing a mode different from the current one raises cache_req with cache_req_mode set to the new value. Readback keeps the old mode until cache_ack, then shows the new one. Mode writes while cache_req is high, and writes of the current mode, are ignored.
- R12: erase_start is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 address low, 2 address high, 3 data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| page_lock | input | 2**PAGE_W | Per-page lock, one bit per page |
| erase_start | output | 1 | One-cycle page-erase start |
| erase_page | output | PAGE_W | Page to erase |
| erase_done | input | 1 | Erase complete pulse from the flash |
| word_valid | output | 1 | Packed word available |
| word_ready | input | 1 | Flash accepts (has programmed) the word |
| word_addr | output | 16 | Word address of the offered word |
| word_data | output | 8*BUF_BYTES | Packed word, first byte lowest |
| cache_mode | output | 2 | Cache mode in force |
| cache_req | output | 1 | Mode change request pending |
| cache_req_mode | output | 2 | Requested mode |
| cache_ack | input | 1 | Cache acknowledges the request |

## Verification
The hardest state to reach is a full buffer that cannot drain. The bench holds the flash model's ready low, pushes five bytes, and observes the full flag and the dropped fifth byte before releasing ready. A second hard case is a locked page reached through auto-increment rather than at the start. The bench starts a session on the last word of an unlocked page, with the next page locked, and streams a second word across the boundary. Erase-then-write ordering is checked by stretching the modelled erase so that data bytes and redundant control writes land while the erase is still running.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam logic [1:0] OFS_CTRL    = 2'd0;
  localparam logic [1:0] OFS_ADDR_LO = 2'd1;
  localparam logic [1:0] OFS_ADDR_HI = 2'd2;
  localparam logic [1:0] OFS_DATA    = 2'd3;

  localparam logic [1:0] CACHE_MODE_RESET = 2'b01;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;
endpackage

// File: rtl/fpr_wbuf.sv
module fpr_wbuf #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               byte_we,
  input  logic [7:0]         byte_in,
  input  logic               drain_en,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [8*BYTES-1:0] out_data,
  output logic               full,
  output logic               byte_taken
);
  localparam int CW = $clog2(BYTES + 1);

  logic [CW-1:0]      count;
  logic [8*BYTES-1:0] data_q;

  assign full       = (count == CW'(BYTES));
  assign byte_taken = byte_we && !full;
  assign out_valid  = full && drain_en;
  assign out_data   = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      data_q <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (out_valid && out_ready) begin
      count <= '0;
    end else if (byte_taken) begin
      for (int i = 0; i < BYTES; i++) begin
        if (count == CW'(i)) data_q[8*i +: 8] <= byte_in;
      end
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/fpr_seq.sv
module fpr_seq
  import fpr_pkg::*;
#(
  parameter int TIMEOUT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic req_erase,
  input  logic req_write,
  input  logic page_locked,
  input  logic erase_done,
  input  logic buf_full,
  input  logic byte_taken,
  output logic erase_bit,
  output logic write_bit,
  output logic abort_bit,
  output logic erase_start,
  output logic buf_clear,
  output logic drain_en
);
  localparam int TW = $clog2(TIMEOUT + 1);

  phase_t        phase;
  logic [TW-1:0] idle_cnt;
  logic          lock_hit;
  logic          time_up;

  assign lock_hit  = (phase == PH_WRITE) && buf_full && page_locked;
  assign time_up   = (phase == PH_WRITE) && !buf_full && !byte_taken &&
                     (idle_cnt == TW'(TIMEOUT - 1));
  assign buf_clear = lock_hit || time_up;
  assign drain_en  = (phase == PH_WRITE) && !page_locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      idle_cnt    <= '0;
      erase_bit   <= 1'b0;
      write_bit   <= 1'b0;
      abort_bit   <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (ctrl_we && (req_erase || req_write)) begin
            if (page_locked) begin
              abort_bit <= 1'b1;
            end else begin
              abort_bit <= 1'b0;
              idle_cnt  <= '0;
              write_bit <= req_write;
              if (req_erase) begin
                erase_bit   <= 1'b1;
                erase_start <= 1'b1;
                phase       <= PH_ERASE;
              end else begin
                phase <= PH_WRITE;
              end
            end
          end
        end
        PH_ERASE: begin
          if (erase_done) begin
            erase_bit <= 1'b0;
            idle_cnt  <= '0;
            phase     <= write_bit ? PH_WRITE : PH_IDLE;
          end
        end
        PH_WRITE: begin
          if (lock_hit) begin
            abort_bit <= 1'b1;
            write_bit <= 1'b0;
            phase     <= PH_IDLE;
          end else if (byte_taken || buf_full) begin
            idle_cnt <= '0;
          end else if (time_up) begin
            write_bit <= 1'b0;
            phase     <= PH_IDLE;
          end else begin
            idle_cnt <= idle_cnt + TW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpr_cache.sv
module fpr_cache
  import fpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_in,
  input  logic       ack,
  output logic [1:0] cur_mode,
  output logic       req,
  output logic [1:0] req_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= CACHE_MODE_RESET;
      req      <= 1'b0;
      req_mode <= CACHE_MODE_RESET;
    end else if (req) begin
      if (ack) begin
        cur_mode <= req_mode;
        req      <= 1'b0;
      end
    end else if (mode_we && (mode_in != cur_mode)) begin
      req      <= 1'b1;
      req_mode <= mode_in;
    end
  end
endmodule

// File: rtl/flash_prog_regs.sv
module flash_prog_regs
  import fpr_pkg::*;
#(
  parameter int PAGE_W        = 7,
  parameter int BUF_BYTES     = 4,
  parameter int WRITE_TIMEOUT = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               reg_addr,
  input  logic                     reg_we,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic [(1<<PAGE_W)-1:0]   page_lock,
  output logic                     erase_start,
  output logic [PAGE_W-1:0]        erase_page,
  input  logic                     erase_done,
  output logic                     word_valid,
  input  logic                     word_ready,
  output logic [15:0]              word_addr,
  output logic [8*BUF_BYTES-1:0]   word_data,
  output logic [1:0]               cache_mode,
  output logic                     cache_req,
  output logic [1:0]               cache_req_mode,
  input  logic                     cache_ack
);
  localparam int WORD_W = 8 * BUF_BYTES;

  logic [7:0]        addr_lo, addr_hi;
  logic [PAGE_W-1:0] page_sel;
  logic              page_locked;
  logic              ctrl_we, data_we;
  logic              erase_bit, write_bit, abort_bit;
  logic              buf_clear, drain_en, buf_full, byte_taken;
  logic              word_done;
  logic [WORD_W-1:0] buf_word;

  assign page_sel    = addr_hi[7 -: PAGE_W];
  assign page_locked = page_lock[page_sel];
  assign ctrl_we     = reg_we && (reg_addr == OFS_CTRL);
  assign data_we     = reg_we && (reg_addr == OFS_DATA) && write_bit;
  assign word_done   = word_valid && word_ready;
  assign word_addr   = {addr_hi, addr_lo};
  assign word_data   = buf_word;
  assign erase_page  = page_sel;

  fpr_seq #(.TIMEOUT(WRITE_TIMEOUT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .req_erase  (reg_wdata[0]),
    .req_write  (reg_wdata[1]),
    .page_locked(page_locked),
    .erase_done (erase_done),
    .buf_full   (buf_full),
    .byte_taken (byte_taken),
    .erase_bit  (erase_bit),
    .write_bit  (write_bit),
    .abort_bit  (abort_bit),
    .erase_start(erase_start),
    .buf_clear  (buf_clear),
    .drain_en   (drain_en)
  );

  fpr_wbuf #(.BYTES(BUF_BYTES)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (buf_clear),
    .byte_we   (data_we),
    .byte_in   (reg_wdata),
    .drain_en  (drain_en),
    .out_ready (word_ready),
    .out_valid (word_valid),
    .out_data  (buf_word),
    .full      (buf_full),
    .byte_taken(byte_taken)
  );

  fpr_cache u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_we (ctrl_we),
    .mode_in (reg_wdata[3:2]),
    .ack     (cache_ack),
    .cur_mode(cache_mode),
    .req     (cache_req),
    .req_mode(cache_req_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
    end else if (word_done) begin
      {addr_hi, addr_lo} <= {addr_hi, addr_lo} + 16'd1;
    end else if (reg_we && (reg_addr == OFS_ADDR_LO)) begin
      addr_lo <= reg_wdata;
    end else if (reg_we && (reg_addr == OFS_ADDR_HI)) begin
      addr_hi <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:    reg_rdata = {write_bit | erase_bit, buf_full, abort_bit, 1'b0,
                                cache_mode, write_bit, erase_bit};
      OFS_ADDR_LO: reg_rdata = addr_lo;
      OFS_ADDR_HI: reg_rdata = addr_hi;
      default:     reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker #(
  parameter int PAGE_W = 7,
  parameter int WORD_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [(1<<PAGE_W)-1:0] page_lock,
  input logic                   erase_start,
  input logic [PAGE_W-1:0]      erase_page,
  input logic                   erase_bit,
  input logic                   word_valid,
  input logic                   word_ready,
  input logic [15:0]            word_addr,
  input logic [WORD_W-1:0]      word_data,
  input logic [1:0]             cache_mode,
  input logic                   cache_req,
  input logic [1:0]             cache_req_mode,
  input logic                   cache_ack
);
  assert_erase_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  assert_erase_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !page_lock[erase_page]);

  assert_word_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !page_lock[word_addr[15 -: PAGE_W]]);

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=>
      (word_valid && $stable(word_data) && $stable(word_addr)));

  assert_no_word_during_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !erase_bit);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req && !cache_ack) |=> (cache_req && $stable(cache_req_mode)));

  assert_mode_needs_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_ack |=> $stable(cache_mode));
endmodule

bind flash_prog_regs fpr_checker #(.PAGE_W(PAGE_W), .WORD_W(8*BUF_BYTES)) u_fpr_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .page_lock     (page_lock),
  .erase_start   (erase_start),
  .erase_page    (erase_page),
  .erase_bit     (erase_bit),
  .word_valid    (word_valid),
  .word_ready    (word_ready),
  .word_addr     (word_addr),
  .word_data     (word_data),
  .cache_mode    (cache_mode),
  .cache_req     (cache_req),
  .cache_req_mode(cache_req_mode),
  .cache_ack     (cache_ack)
);

// File: tb/flash_prog_regs_bench.sv
module flash_prog_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;
  localparam int ERASE_CYC  = 30;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic [127:0] page_lock = '0;
  logic         erase_start;
  logic [6:0]   erase_page;
  logic         erase_done;
  logic         word_valid, word_ready;
  logic [15:0]  word_addr;
  logic [31:0]  word_data;
  logic [1:0]   cache_mode, cache_req_mode;
  logic         cache_req;
  logic         cache_ack = 1'b0;
  logic         hold_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_regs #(.PAGE_W(7), .BUF_BYTES(4), .WRITE_TIMEOUT(TMO)) u_flash_prog_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_lock(page_lock),
    .erase_start(erase_start), .erase_page(erase_page), .erase_done(erase_done),
    .word_valid(word_valid), .word_ready(word_ready), .word_addr(word_addr),
    .word_data(word_data), .cache_mode(cache_mode), .cache_req(cache_req),
    .cache_req_mode(cache_req_mode), .cache_ack(cache_ack)
  );

  // flash model
  int          ecnt = 0;
  int          erase_n = 0;
  logic [6:0]  last_page = '0;
  bit          early_word = 0;
  logic [1:0]  wdly = '0;
  logic [15:0] cap_addr [0:31];
  logic [31:0] cap_data [0:31];
  int          cap_n = 0;

  assign erase_done = (ecnt == ERASE_CYC);
  assign word_ready = word_valid && !hold_ready && (wdly == 2'd2);

  always @(posedge clk) begin
    if (!rst_n) begin
      ecnt <= 0;
    end else if (erase_start) begin
      ecnt <= 1;
      erase_n <= erase_n + 1;
      last_page <= erase_page;
    end else if (ecnt != 0 && ecnt < ERASE_CYC) begin
      ecnt <= ecnt + 1;
    end else begin
      ecnt <= 0;
    end
    wdly <= (word_valid && !word_ready && !hold_ready) ? wdly + 2'd1 : 2'd0;
    if (rst_n && word_valid && ecnt != 0) early_word <= 1;
    if (rst_n && word_valid && word_ready) begin
      cap_addr[cap_n] <= word_addr;
      cap_data[cap_n] <= word_data;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_caps(input int n);
    while (cap_n < n) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    rd(2'd0, v);
    while (v[7]) rd(2'd0, v);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    finish_run();
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] w;
    int base_caps, base_er;
    logic [1:0]  cur;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h04);
    rd(2'd1, v); chk("R1 addr lo", v, 8'h00);
    rd(2'd2, v); chk("R1 addr hi", v, 8'h00);
    rd(2'd3, v); chk("R1 data", v, 8'h00);

    // R3 data byte while idle is ignored
    wr(2'd3, 8'h55);
    rd(2'd0, v); chk("R3 idle byte ignored", v, 8'h04);

    // R6 streaming sweep across a low-byte carry
    wr(2'd2, 8'h02); wr(2'd1, 8'hFE);
    wr(2'd0, 8'h06);
    rd(2'd0, v); chk("R2 busy+write", v, 8'h86);
    for (int n = 0; n < 8; n++) begin
      for (int i = 0; i < 4; i++) wr(2'd3, 8'(n*16 + i + 1));
      wait_caps(n + 1);
      w = 0;
      for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'(n*16 + i + 1);
      chk("R3 little-endian word", cap_data[n], w);
      chk("R6 word address", {16'h0, cap_addr[n]}, 32'(16'h02FE + n));
    end
    rd(2'd1, v); chk("R6 lo after carry", v, 8'h06);
    rd(2'd2, v); chk("R6 hi after carry", v, 8'h03);
    rd(2'd3, v); chk("R3 data reads zero", v, 8'h00);
    // R10 timeout
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R10 still busy before timeout", v, 8'h86);
    repeat (TMO + 4) @(negedge clk);
    rd(2'd0, v); chk("R10 ended by timeout", v, 8'h04);

    // R4 full and dropped byte
    wr(2'd2, 8'h04); wr(2'd1, 8'h00);
    hold_ready = 1'b1;
    wr(2'd0, 8'h06);
    for (int i = 0; i < 5; i++) wr(2'd3, 8'hA0 + 8'(i));
    rd(2'd0, v); chk("R4 full set", v, 8'hC6);
    base_caps = cap_n;
    hold_ready = 1'b0;
    wait_caps(base_caps + 1);
    chk("R4 first word", cap_data[base_caps], 32'hA3A2A1A0);
    rd(2'd0, v); chk("R4 full cleared", v, 8'h86);
    for (int i = 0; i < 4; i++) wr(2'd3, 8'hB0 + 8'(i));
    wait_caps(base_caps + 2);
    chk("R4 extra byte dropped", cap_data[base_caps + 1], 32'hB3B2B1B0);
    wait_idle();

    // R8 erase then write, R9 writes while busy
    wr(2'd2, 8'h0C); wr(2'd1, 8'h10);
    base_er = erase_n; base_caps = cap_n;
    wr(2'd0, 8'h07);
    rd(2'd0, v); chk("R8 erase+write started", v, 8'h87);
    chk("R8 erase strobe count", erase_n, base_er + 1);
    chk("R8 erase page", {25'h0, last_page}, 32'd6);
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R9 zero write cancels nothing", v, 8'h87);
    wr(2'd0, 8'h05);
    chk("R9 no second erase", erase_n, base_er + 1);
    for (int i = 0; i < 4; i++) wr(2'd3, 8'hC0 + 8'(i));
    wait_caps(base_caps + 1);
    chk("R8 no word during erase", {31'h0, early_word}, 32'd0);
    chk("R8 word after erase", cap_data[base_caps], 32'hC3C2C1C0);
    chk("R8 word address", {16'h0, cap_addr[base_caps]}, 32'h0C10);
    wait_idle();
    rd(2'd0, v); chk("R8 idle after session", v, 8'h04);

    // R7 locked page
    page_lock[5] = 1'b1;
    base_er = erase_n; base_caps = cap_n;
    wr(2'd2, 8'h0A); wr(2'd1, 8'h00);
    wr(2'd0, 8'h06);
    rd(2'd0, v); chk("R7 write abort", v, 8'h24);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R7 erase abort", v, 8'h24);
    chk("R7 no erase strobe", erase_n, base_er);
    wr(2'd2, 8'h0C);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R7 abort cleared by start", v, 8'h85);
    wait_idle();
    wr(2'd2, 8'h09); wr(2'd1, 8'hFF);
    wr(2'd0, 8'h06);
    for (int i = 0; i < 4; i++) wr(2'd3, 8'hD0 + 8'(i));
    wait_caps(base_caps + 1);
    for (int i = 0; i < 4; i++) wr(2'd3, 8'hE0 + 8'(i));
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R7 abort on crossing into locked page", v, 8'h24);
    chk("R7 no locked word", cap_n, base_caps + 1);
    rd(2'd2, v); chk("R7 address reached locked page", v, 8'h0A);

    // R11 cache mode sweep
    cur = 2'b01;
    wr(2'd0, {4'h0, cur, 2'b00});
    chk("R11 same mode no request", {31'h0, cache_req}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] m;
      m = 2'((k + 2) % 4);
      wr(2'd0, {4'h0, m, 2'b00});
      chk("R11 request raised", {31'h0, cache_req}, 32'd1);
      chk("R11 request mode", {30'h0, cache_req_mode}, {30'h0, m});
      rd(2'd0, v); chk("R11 old mode until ack", {30'h0, v[3:2]}, {30'h0, cur});
      wr(2'd0, {4'h0, ~m, 2'b00});
      chk("R11 write ignored while pending", {30'h0, cache_req_mode}, {30'h0, m});
      @(negedge clk); cache_ack = 1'b1;
      @(negedge clk); cache_ack = 1'b0;
      rd(2'd0, v); chk("R11 new mode after ack", {30'h0, v[3:2]}, {30'h0, m});
      chk("R11 request dropped", {31'h0, cache_req}, 32'd0);
      cur = m;
    end

    finish_run();
  end
endmodule